// File: doc/BRIEF.md
# Multi-Window Pixel Store

This block holds a frame of pixels, each kept as one 26-bit word: a 24-bit colour value in the low bits and a 2-bit display mode on top. A host reaches the same storage through three address windows, each with its own width and protection rule. The two top address bits choose the window.

The full-control window exposes every stored bit. The colour-only window shows the 24 colour bits and cannot alter the mode. The byte window packs one byte per pixel and touches only the low eight bits. A write through a narrow window is merged into the stored word within one host cycle. A second read-only port gives the display pipeline the whole 26-bit word of any pixel.

The number of pixels is a parameter. Addresses past the last pixel, and the fourth window code, read as zero and ignore writes.

Top module: `pixel_window_store`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_data` and `scan_data` are zero. Every stored word is zero after reset.
- R2: `bus_addr[19:18]` selects the window: 00 is the byte window, 01 colour-only, 10 full-control and 11 unmapped. Unmapped reads return zero and unmapped writes change no pixel.
- R3: In the full-control window a write stores `bus_wdata[25:0]` and ignores bits 31:26. A read returns the 26-bit word with bits 31:26 zero.
- R4: In the colour-only window a read returns the colour in bits 23:0 with bits 31:24 zero. A write replaces only colour bits 23:0 and keeps the stored mode bits 25:24.
- R5: In the byte window a read returns stored bits 7:0 in `rd_data[7:0]` with the rest zero. A write replaces only stored bits 7:0 and keeps stored bits 25:8.
- R6: A window offset (`bus_addr[17:0]`) of DEPTH or more is out of range. It reads zero and its writes change no pixel, including offsets whose low bits match a real pixel.
- R7: `rd_data` shows the result for the address presented one clock edge earlier. A read of a pixel written in the same cycle returns the value it held before that write.
- R8: `scan_data` is the full 26-bit word at `scan_addr`, one clock edge later. A scan of a pixel written in the same cycle returns the old word, and the new word one cycle after. A scan index of DEPTH or more returns zero.
- R9: The mode field in bits 25:24 holds the codes 00 (8-bit index through the colour table), 01 (24-bit colour through the table) and 11 (direct 24-bit colour). It is kept unchanged and shown by the scan port, and only the full-control window can set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (20) | Host address: window code in the top two bits, pixel offset below |
| bus_we | input | 1 | Host write enable |
| bus_wdata | input | 32 | Host write data |
| rd_data | output | 32 | Host read data for the previous cycle's address |
| scan_addr | input | IDX_W (6) | Scan-out pixel index |
| scan_data | output | 26 | Scan-out pixel word |

## Verification
The hardest case to reach is a write and a scan read that meet on the same pixel in the same cycle. The scan must then return the whole old word and show the new word one cycle later, with no mix of the two. The bench drives the write and the scan index together on one falling edge. It then samples the scan output on each of the next two falling edges.

A second hard case is an out-of-range offset whose truncated low bits name a real pixel. The bench writes such an offset and then reads pixel zero through the full-control window to show it is still untouched.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  localparam int PIX_W = 26;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    WIN_BYTE   = 2'b00,
    WIN_COLOUR = 2'b01,
    WIN_FULL   = 2'b10,
    WIN_NONE   = 2'b11
  } win_t;

  // Word stored after a host write through window w.
  function automatic logic [PIX_W-1:0] merge_word(win_t w, logic [PIX_W-1:0] old,
                                                   logic [BUS_W-1:0] wd);
    case (w)
      WIN_BYTE:   return {old[25:8], wd[7:0]};
      WIN_COLOUR: return {old[25:24], wd[23:0]};
      WIN_FULL:   return wd[25:0];
      default:    return old;
    endcase
  endfunction

  // Host-visible form of a stored word through window w.
  function automatic logic [BUS_W-1:0] view_word(win_t w, logic [PIX_W-1:0] word);
    case (w)
      WIN_BYTE:   return {24'd0, word[7:0]};
      WIN_COLOUR: return {8'd0, word[23:0]};
      WIN_FULL:   return {6'd0, word};
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/pwin_decode.sv
module pwin_decode
  import pwin_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 48,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output win_t              win,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  localparam int OFF_W = ADDR_W - 2;

  logic [OFF_W-1:0] off;

  assign off = addr[OFF_W-1:0];
  assign win = win_t'(addr[ADDR_W-1 -: 2]);
  assign idx = off[IDX_W-1:0];
  // Full-width compare so that large offsets never alias a real pixel.
  assign hit = (win != WIN_NONE) && (off < OFF_W'(DEPTH));
endmodule

// File: rtl/pwin_lane.sv
module pwin_lane
  import pwin_pkg::*;
(
  input  win_t             win,
  input  logic             hit,
  input  logic [PIX_W-1:0] old_word,
  input  logic [BUS_W-1:0] wdata,
  output logic [PIX_W-1:0] new_word,
  output logic [BUS_W-1:0] view
);
  assign new_word = merge_word(win, old_word, wdata);
  assign view     = hit ? view_word(win, old_word) : '0;
endmodule

// File: rtl/pwin_store.sv
module pwin_store
  import pwin_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_fire,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PIX_W-1:0] wr_word,
  input  logic [IDX_W-1:0] look_idx,
  output logic [PIX_W-1:0] look_word,
  input  logic [IDX_W-1:0] scan_idx,
  output logic [PIX_W-1:0] scan_word
);
  logic [PIX_W-1:0] mem [DEPTH];
  logic             look_ok;
  logic             scan_ok;

  assign look_ok   = 32'(look_idx) < DEPTH;
  assign scan_ok   = 32'(scan_idx) < DEPTH;
  assign look_word = look_ok ? mem[look_idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      scan_word <= '0;
    end else begin
      if (wr_fire) mem[wr_idx] <= wr_word;
      scan_word <= scan_ok ? mem[scan_idx] : '0;
    end
  end

  // R6: the decoder never lets a write reach past the array
  a_r6_write_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> (32'(wr_idx) < DEPTH));

  // R3: an accepted write lands whole in its word
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (mem[$past(wr_idx)] == $past(wr_word)));
endmodule

// File: rtl/pixel_window_store.sv
module pixel_window_store
  import pwin_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 48,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      rd_data,
  input  logic [IDX_W-1:0] scan_addr,
  output logic [25:0]      scan_data
);
  win_t             win;
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic             wr_fire;
  logic [PIX_W-1:0] old_word;
  logic [PIX_W-1:0] new_word;
  logic [BUS_W-1:0] view;

  pwin_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .win(win), .idx(idx), .hit(hit)
  );

  pwin_lane u_lane (
    .win(win), .hit(hit), .old_word(old_word), .wdata(bus_wdata),
    .new_word(new_word), .view(view)
  );

  assign wr_fire = bus_we && hit;

  pwin_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_fire(wr_fire), .wr_idx(idx), .wr_word(new_word),
    .look_idx(idx), .look_word(old_word),
    .scan_idx(scan_addr), .scan_word(scan_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= view;
  end

  // R1: outputs are clear in the first cycle after reset
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == 32'd0 && scan_data == 26'd0));

  // R2: the unmapped window reads zero
  a_r2_none_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (win == WIN_NONE) |=> (rd_data == 32'd0));

  // R3: full-control reads have a zero pad above bit 25
  a_r3_full_pad: assert property (@(posedge clk) disable iff (rst)
    (win == WIN_FULL) |=> (rd_data[31:26] == 6'd0));

  // R4: colour-only writes keep the mode bits
  a_r4_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && win == WIN_COLOUR) |-> (new_word[25:24] == old_word[25:24]));

  // R4: colour-only reads have a zero upper byte
  a_r4_colour_pad: assert property (@(posedge clk) disable iff (rst)
    (win == WIN_COLOUR) |=> (rd_data[31:24] == 8'd0));

  // R5: byte writes keep stored bits 25:8
  a_r5_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && win == WIN_BYTE) |-> (new_word[25:8] == old_word[25:8]));

  // R5: byte reads return only the low eight bits
  a_r5_byte_pad: assert property (@(posedge clk) disable iff (rst)
    (win == WIN_BYTE) |=> (rd_data[31:8] == 24'd0));

  // R6: out-of-range offsets read zero
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (!hit) |=> (rd_data == 32'd0));
endmodule

// File: tb/sim_pixel_window_store.sv
module sim_pixel_window_store;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic [5:0]  scan_addr = '0;
  logic [25:0] scan_data;

  int total = 0;
  int bad   = 0;

  localparam logic [19:0] B_BYTE = 20'h00000;
  localparam logic [19:0] B_COL  = 20'h40000;
  localparam logic [19:0] B_FULL = 20'h80000;
  localparam logic [19:0] B_NONE = 20'hC0000;

  // {write, requirement number, address, write data or expected read}
  localparam int NV = 19;
  localparam logic [56:0] VEC [NV] = '{
    {1'b1, 4'd3, B_FULL + 20'd5,  32'hFFFF_FFFF},
    {1'b0, 4'd3, B_FULL + 20'd5,  32'h03FF_FFFF},
    {1'b1, 4'd4, B_COL  + 20'd5,  32'hAB12_3456},
    {1'b0, 4'd4, B_FULL + 20'd5,  32'h0312_3456},
    {1'b0, 4'd4, B_COL  + 20'd5,  32'h0012_3456},
    {1'b1, 4'd5, B_BYTE + 20'd5,  32'hFFFF_FF9C},
    {1'b0, 4'd5, B_FULL + 20'd5,  32'h0312_349C},
    {1'b0, 4'd5, B_BYTE + 20'd5,  32'h0000_009C},
    {1'b1, 4'd9, B_FULL + 20'd7,  32'h01AB_CDEF},
    {1'b0, 4'd4, B_COL  + 20'd7,  32'h00AB_CDEF},
    {1'b1, 4'd2, B_NONE + 20'd7,  32'hFFFF_FFFF},
    {1'b0, 4'd2, B_FULL + 20'd7,  32'h01AB_CDEF},
    {1'b0, 4'd2, B_NONE + 20'd7,  32'h0000_0000},
    {1'b1, 4'd6, B_FULL + 20'd48, 32'h0222_2222},
    {1'b0, 4'd6, B_FULL + 20'd48, 32'h0000_0000},
    {1'b1, 4'd6, B_BYTE + 20'd64, 32'h0000_0055},
    {1'b0, 4'd6, B_FULL + 20'd0,  32'h0000_0000},
    {1'b1, 4'd6, B_FULL + 20'd47, 32'h0000_0011},
    {1'b0, 4'd6, B_FULL + 20'd47, 32'h0000_0011}
  };

  pixel_window_store u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .rd_data(rd_data),
    .scan_addr(scan_addr), .scan_data(scan_data)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at zero while reset is applied
    chk(rd_data == 0, "R1", rd_data, 0);
    chk(scan_data == 0, "R1", {6'd0, scan_data}, 0);
    rst = 1'b0;
    bus_addr = B_FULL + 20'd3;
    @(negedge clk);
    // R1: a stored word reads zero after reset
    chk(rd_data == 0, "R1", rd_data, 0);

    for (int i = 0; i < NV; i++) begin
      bus_we    = VEC[i][56];
      bus_addr  = VEC[i][51:32];
      bus_wdata = VEC[i][31:0];
      @(negedge clk);
      bus_we = 1'b0;
      if (!VEC[i][56])
        chk(rd_data == VEC[i][31:0], $sformatf("R%0d", VEC[i][55:52]),
            rd_data, VEC[i][31:0]);
    end

    // R7: one edge of latency; the value does not move before the edge
    bus_addr = B_FULL + 20'd7;
    @(negedge clk);
    bus_addr = B_FULL + 20'd5;
    #1;
    chk(rd_data == 32'h01AB_CDEF, "R7", rd_data, 32'h01AB_CDEF);
    @(negedge clk);
    chk(rd_data == 32'h0312_349C, "R7", rd_data, 32'h0312_349C);

    // R7: read of a pixel written in the same cycle gives the old value
    bus_addr = B_FULL + 20'd5;
    bus_we = 1'b1;
    bus_wdata = 32'h0000_1111;
    @(negedge clk);
    bus_we = 1'b0;
    chk(rd_data == 32'h0312_349C, "R7", rd_data, 32'h0312_349C);
    @(negedge clk);
    chk(rd_data == 32'h0000_1111, "R7", rd_data, 32'h0000_1111);

    // R9: mode codes 01 and 00 seen on the scan port
    scan_addr = 6'd7;
    @(negedge clk);
    chk(scan_data == 26'h1AB_CDEF, "R9", {6'd0, scan_data}, 32'h01AB_CDEF);
    chk(scan_data[25:24] == 2'b01, "R9", {30'd0, scan_data[25:24]}, 1);
    scan_addr = 6'd47;
    @(negedge clk);
    chk(scan_data[25:24] == 2'b00, "R9", {30'd0, scan_data[25:24]}, 0);

    // R9: direct-colour mode 11 set by full view, kept by a colour write
    bus_addr = B_FULL + 20'd9;
    bus_we = 1'b1;
    bus_wdata = 32'h0300_0077;
    scan_addr = 6'd9;
    @(negedge clk);
    // R8: same-cycle scan returns the old word
    chk(scan_data == 26'd0, "R8", {6'd0, scan_data}, 0);
    bus_addr = B_COL + 20'd9;
    bus_wdata = 32'hFF00_0088;
    @(negedge clk);
    bus_we = 1'b0;
    // R8: the new word one cycle later
    chk(scan_data == 26'h300_0077, "R8", {6'd0, scan_data}, 32'h0300_0077);
    @(negedge clk);
    chk(scan_data == 26'h300_0088, "R9", {6'd0, scan_data}, 32'h0300_0088);

    // R8: scan index past the last pixel returns zero
    scan_addr = 6'd50;
    @(negedge clk);
    chk(scan_data == 26'd0, "R8", {6'd0, scan_data}, 0);

    // R1: a second reset clears stored words
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    bus_addr = B_FULL + 20'd9;
    scan_addr = 6'd7;
    @(negedge clk);
    chk(rd_data == 0, "R1", rd_data, 0);
    chk(scan_data == 0, "R1", {6'd0, scan_data}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule